// File: doc/BRIEF.md
# Split Time-Base Event Timestamp Timer

This block keeps a running time value for scheduling and stamping radio events. A low counter runs through one programmable period and then starts again from zero. Each completed period advances a high counter that records how many periods have gone by. The two counters read together, high above low, form one wide time value. Either of two event strobes latches that whole value into a capture register. The strobes mark a detected frame delimiter and the end of a transmission.

Two compare units watch the low counter and two watch the high counter. Each unit emits a one-cycle pulse on a match, which can be used to start reception or transmission at an exact time. Each match also sets a sticky flag. Software reaches the timer through a byte-wide register port. The address is split as `reg_addr[5:3]` = register and `reg_addr[2:0]` = byte lane, with lane 0 as the least significant byte.

The counting control is a two-state machine, STOPPED and RUNNING. In STOPPED, counting is frozen and a newly written period is adopted on every edge. The transition STOPPED to RUNNING is taken when the run bit is 1. The transition RUNNING to STOPPED is taken when the run bit is 0. In RUNNING, the counters advance every cycle and the period is adopted only at a period boundary.

Top module: `evt_stamp_timer`

## Requirements
- R1: While RUNNING, on each clock edge the low counter goes up by one. At the edge where it is greater than or equal to the active period P, it returns to 0 instead, so one period lasts P+1 cycles.
- R2: The high counter goes up by one exactly at the edges where the low counter returns to 0, and holds its value at every other edge.
- R3: Register 0 lane 0 controls counting. Bit 0 is run: the state machine follows it one edge after the write, so the first count happens at the second edge after the writing edge. While STOPPED both counters hold. Writing bit 1 as 1 clears both counters at that write edge, and this clear takes priority over counting.
- R4: The period (register 1) resets to all ones. While RUNNING, a written period becomes active at the next return to 0, so the period in progress completes with its old length. While STOPPED, the written period is adopted at the next edge.
- R5: A strobe on `sof_strobe` or `eot_strobe` copies {high, low} as they stand in the strobe cycle into the capture register (register 6). Reading lane 0 returns capture bits 7:0 and, at the same edge, freezes bits above 7 into a shadow. Lanes 1 and up return the shadow, so a later strobe cannot tear a multi-byte read.
- R6: `lo_match[i]` is high for exactly the cycle after each RUNNING cycle in which the low counter equals low compare i (registers 2 and 3).
- R7: `hi_match[i]` is high for the cycle after the period-boundary edge whose incremented high value equals high compare i (registers 4 and 5).
- R8: Flags live in register 7 lane 0 and drive `flags_out`. The bits are: 1:0 low matches, 3:2 high matches, 4 high wrap, 5 capture. They are set together with their pulse and stay set. Writing 1 clears a bit, and a new set in the same cycle wins.
- R9: The high counter wraps from all ones to 0 and keeps counting; that wrap sets flag bit 4.
- R10: Read data appears on `reg_rdata` after the edge that samples `reg_rd` and holds until the next read. Lanes above a register's width read 0 and ignore writes. Register 0 reads back the run bit in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | {register, byte lane} |
| reg_wdata | input | 8 | Write byte |
| reg_rdata | output | 8 | Registered read byte |
| sof_strobe | input | 1 | Frame-delimiter event, latches time |
| eot_strobe | input | 1 | End-of-transmission event, latches time |
| lo_match | output | 2 | Low compare pulses |
| hi_match | output | 2 | High compare pulses |
| flags_out | output | 6 | Sticky event flags |

## Verification
The bench builds the timer with both counters 8 bits wide. At that size a full high-counter wrap takes only 256 periods, and a 16-bit capture fits in two lanes. The bench sweeps several periods, including the degenerate period 0, with compare values at mid-period, at the boundary and at the wrap point. It also changes the period mid-run and checks pulses and flags on every cycle against an arithmetic model kept in the bench.

// File: rtl/ts_pkg.sv
package ts_pkg;

    typedef enum logic {
        TB_STOPPED = 1'b0,
        TB_RUNNING = 1'b1
    } tb_state_e;

    localparam int NCMP   = 2;
    localparam int FLAG_W = 2 * NCMP + 2;

    localparam logic [2:0] REG_CTRL   = 3'd0;
    localparam logic [2:0] REG_PERIOD = 3'd1;
    localparam logic [2:0] REG_LCMP   = 3'd2;
    localparam logic [2:0] REG_HCMP   = 3'd4;
    localparam logic [2:0] REG_CAPT   = 3'd6;
    localparam logic [2:0] REG_FLAGS  = 3'd7;

    localparam int FLG_WRAP = 2 * NCMP;
    localparam int FLG_CAPT = 2 * NCMP + 1;

    function automatic logic [63:0] put_byte(input logic [63:0] v,
                                             input logic [2:0]  lane,
                                             input logic [7:0]  d);
        logic [63:0] r;
        r = v;
        r[lane*8 +: 8] = d;
        return r;
    endfunction

    function automatic logic [7:0] get_byte(input logic [63:0] v,
                                            input logic [2:0]  lane);
        return v[lane*8 +: 8];
    endfunction

endpackage

// File: rtl/ts_timebase.sv
module ts_timebase
    import ts_pkg::*;
#(
    parameter int LO_W = 16,
    parameter int HI_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_req,
    input  logic            zero_req,
    input  logic [LO_W-1:0] period_pend,
    output logic [LO_W-1:0] lo_cnt,
    output logic [HI_W-1:0] hi_cnt,
    output logic [HI_W-1:0] hi_next,
    output logic [LO_W-1:0] per_act,
    output logic            running,
    output logic            period_done,
    output logic            hi_roll
);

    tb_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TB_STOPPED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        running = 1'b0;
        unique case (state_q)
            TB_STOPPED: begin
                running = 1'b0;
                if (run_req) state_d = TB_RUNNING;
            end
            TB_RUNNING: begin
                running = 1'b1;
                if (!run_req) state_d = TB_STOPPED;
            end
        endcase
    end

    assign period_done = running && !zero_req && (lo_cnt >= per_act);
    assign hi_next     = hi_cnt + 1'b1;
    assign hi_roll     = period_done && (&hi_cnt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt <= '0;
            hi_cnt <= '0;
        end else if (zero_req) begin
            lo_cnt <= '0;
            hi_cnt <= '0;
        end else if (period_done) begin
            lo_cnt <= '0;
            hi_cnt <= hi_next;
        end else if (running) begin
            lo_cnt <= lo_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       per_act <= '1;
        else if (!running || period_done) per_act <= period_pend;
    end

endmodule

// File: rtl/ts_match.sv
module ts_match #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] value,
    input  logic [W-1:0] cmp,
    output logic         hit,
    output logic         pulse
);

    assign hit = en && (value == cmp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= hit;
    end

endmodule

// File: rtl/ts_capture.sv
module ts_capture #(
    parameter int CAP_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [CAP_W-1:0] stamp,
    input  logic             freeze,
    output logic [CAP_W-1:0] cap_q,
    output logic [CAP_W-9:0] shadow_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cap_q <= '0;
        else if (take) cap_q <= stamp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      shadow_q <= '0;
        else if (freeze) shadow_q <= cap_q[CAP_W-1:8];
    end

endmodule

// File: rtl/evt_stamp_timer.sv
module evt_stamp_timer
    import ts_pkg::*;
#(
    parameter int LO_W = 16,
    parameter int HI_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [5:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              sof_strobe,
    input  logic              eot_strobe,
    output logic [NCMP-1:0]   lo_match,
    output logic [NCMP-1:0]   hi_match,
    output logic [FLAG_W-1:0] flags_out
);

    localparam int CAP_W = LO_W + HI_W;
    localparam int SH_W  = CAP_W - 8;

    logic [2:0] sel_reg, sel_lane;
    assign sel_reg  = reg_addr[5:3];
    assign sel_lane = reg_addr[2:0];

    logic            ctrl_run;
    logic [LO_W-1:0] period_pend;
    logic [LO_W-1:0] lo_cmp [NCMP];
    logic [HI_W-1:0] hi_cmp [NCMP];
    logic [FLAG_W-1:0] flags_q;

    logic zero_req;
    assign zero_req = reg_wr && (sel_reg == REG_CTRL) && (sel_lane == 3'd0) && reg_wdata[1];

    logic [LO_W-1:0] tb_lo, tb_per;
    logic [HI_W-1:0] tb_hi, tb_hi_next;
    logic            tb_running, tb_done, tb_roll;

    ts_timebase #(.LO_W(LO_W), .HI_W(HI_W)) u_timebase (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_req     (ctrl_run),
        .zero_req    (zero_req),
        .period_pend (period_pend),
        .lo_cnt      (tb_lo),
        .hi_cnt      (tb_hi),
        .hi_next     (tb_hi_next),
        .per_act     (tb_per),
        .running     (tb_running),
        .period_done (tb_done),
        .hi_roll     (tb_roll)
    );

    logic [NCMP-1:0] lo_hit, hi_hit;

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        ts_match #(.W(LO_W)) u_lo (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (tb_running),
            .value (tb_lo),
            .cmp   (lo_cmp[g]),
            .hit   (lo_hit[g]),
            .pulse (lo_match[g])
        );
        ts_match #(.W(HI_W)) u_hi (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (tb_done),
            .value (tb_hi_next),
            .cmp   (hi_cmp[g]),
            .hit   (hi_hit[g]),
            .pulse (hi_match[g])
        );
    end

    logic             cap_take, cap_freeze;
    logic [CAP_W-1:0] cap_q;
    logic [SH_W-1:0]  shadow_q;

    assign cap_take   = sof_strobe || eot_strobe;
    assign cap_freeze = reg_rd && (sel_reg == REG_CAPT) && (sel_lane == 3'd0);

    ts_capture #(.CAP_W(CAP_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (cap_take),
        .stamp    ({tb_hi, tb_lo}),
        .freeze   (cap_freeze),
        .cap_q    (cap_q),
        .shadow_q (shadow_q)
    );

    // configuration writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_run    <= 1'b0;
            period_pend <= '1;
            for (int i = 0; i < NCMP; i++) begin
                lo_cmp[i] <= '0;
                hi_cmp[i] <= '0;
            end
        end else if (reg_wr) begin
            if (sel_reg == REG_CTRL && sel_lane == 3'd0)
                ctrl_run <= reg_wdata[0];
            if (sel_reg == REG_PERIOD)
                period_pend <= LO_W'(put_byte(64'(period_pend), sel_lane, reg_wdata));
            for (int i = 0; i < NCMP; i++) begin
                if (sel_reg == REG_LCMP + 3'(i))
                    lo_cmp[i] <= LO_W'(put_byte(64'(lo_cmp[i]), sel_lane, reg_wdata));
                if (sel_reg == REG_HCMP + 3'(i))
                    hi_cmp[i] <= HI_W'(put_byte(64'(hi_cmp[i]), sel_lane, reg_wdata));
            end
        end
    end

    // sticky flags, set wins over write-one-clear
    logic [FLAG_W-1:0] flag_set, flag_clr;
    always_comb begin
        flag_set = {cap_take, tb_roll, hi_hit, lo_hit};
        flag_clr = '0;
        if (reg_wr && sel_reg == REG_FLAGS && sel_lane == 3'd0)
            flag_clr = reg_wdata[FLAG_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~flag_clr) | flag_set;
    end

    assign flags_out = flags_q;

    // read path
    logic [7:0] rd_mux;
    always_comb begin
        rd_mux = 8'h00;
        unique case (sel_reg)
            REG_CTRL:   rd_mux = (sel_lane == 3'd0) ? {7'b0, ctrl_run} : 8'h00;
            REG_PERIOD: rd_mux = get_byte(64'(period_pend), sel_lane);
            3'd2, 3'd3: rd_mux = get_byte(64'(lo_cmp[sel_reg[0]]), sel_lane);
            3'd4, 3'd5: rd_mux = get_byte(64'(hi_cmp[sel_reg[0]]), sel_lane);
            REG_CAPT:   rd_mux = (sel_lane == 3'd0) ? cap_q[7:0]
                                 : get_byte(64'(shadow_q), sel_lane - 3'd1);
            REG_FLAGS:  rd_mux = (sel_lane == 3'd0) ? 8'(flags_q) : 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_rdata <= 8'h00;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

endmodule

// File: rtl/ts_checker.sv
module ts_checker
    import ts_pkg::*;
#(
    parameter int LO_W = 16,
    parameter int HI_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              zero_req,
    input logic              running,
    input logic              period_done,
    input logic [LO_W-1:0]   lo_cnt,
    input logic [HI_W-1:0]   hi_cnt,
    input logic [LO_W-1:0]   per_act,
    input logic [NCMP-1:0]   lo_match,
    input logic [NCMP-1:0]   hi_match,
    input logic [FLAG_W-1:0] flags_out
);

    AST_LO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !zero_req && lo_cnt < per_act) |=> lo_cnt == LO_W'($past(lo_cnt) + 1)); // R1
    AST_LO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        period_done |=> lo_cnt == '0); // R1
    AST_HI_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        period_done |=> hi_cnt == HI_W'($past(hi_cnt) + 1)); // R2
    AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!period_done && !zero_req) |=> $stable(hi_cnt)); // R2
    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !zero_req) |=> $stable(lo_cnt)); // R3
    AST_ZERO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        zero_req |=> (lo_cnt == '0 && hi_cnt == '0)); // R3
    AST_LO_PULSE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (|lo_match) |-> $past(running)); // R6
    AST_HI_PULSE_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (|hi_match) |-> $past(period_done)); // R7
    AST_PULSE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        ((lo_match & ~flags_out[NCMP-1:0]) == '0 &&
         (hi_match & ~flags_out[2*NCMP-1:NCMP]) == '0)); // R8
    AST_HI_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (period_done && (&hi_cnt)) |=> (hi_cnt == '0 && flags_out[FLG_WRAP])); // R9

endmodule

bind evt_stamp_timer ts_checker #(.LO_W(LO_W), .HI_W(HI_W)) u_ts_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .zero_req    (zero_req),
    .running     (tb_running),
    .period_done (tb_done),
    .lo_cnt      (tb_lo),
    .hi_cnt      (tb_hi),
    .per_act     (tb_per),
    .lo_match    (lo_match),
    .hi_match    (hi_match),
    .flags_out   (flags_out)
);

// File: tb/evt_stamp_timer_bench.sv
`timescale 1ns/1ps
module evt_stamp_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       b_wr = 1'b0, b_rd = 1'b0, b_sof = 1'b0, b_eot = 1'b0;
    logic [5:0] b_addr = '0;
    logic [7:0] b_wdata = '0;
    logic [7:0] rdata;
    logic [1:0] lo_match, hi_match;
    logic [5:0] flags_out;

    always #5 clk = ~clk;

    evt_stamp_timer #(.LO_W(8), .HI_W(8)) u_evt_stamp_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (b_wr),
        .reg_rd     (b_rd),
        .reg_addr   (b_addr),
        .reg_wdata  (b_wdata),
        .reg_rdata  (rdata),
        .sof_strobe (b_sof),
        .eot_strobe (b_eot),
        .lo_match   (lo_match),
        .hi_match   (hi_match),
        .flags_out  (flags_out)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // arithmetic model of the requirements
    logic [7:0]  m_lo, m_hi, m_per, m_pend;
    logic        m_state, m_ctrl;
    logic [7:0]  m_lcmp [2];
    logic [7:0]  m_hcmp [2];
    logic [15:0] m_cap;
    logic [7:0]  m_shadow;
    logic [5:0]  m_flags;
    logic [1:0]  m_lp, m_hp;
    string       rd_tag;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [5:0] a);
        logic [2:0] r, l;
        r = a[5:3];
        l = a[2:0];
        if (l == 3'd1 && r == 3'd6) return m_shadow;
        if (l != 3'd0) return 8'h00;
        case (r)
            3'd0: return {7'b0, m_ctrl};
            3'd1: return m_pend;
            3'd2: return m_lcmp[0];
            3'd3: return m_lcmp[1];
            3'd4: return m_hcmp[0];
            3'd5: return m_hcmp[1];
            3'd6: return m_cap[7:0];
            default: return {2'b0, m_flags};
        endcase
    endfunction

    // one clock: entered and left at a negedge, inputs already driven
    task automatic step();
        logic       zero, done, cap_ev, do_rd;
        logic [1:0] lh, hh;
        logic [5:0] clr, set;
        logic [7:0] erd;
        @(posedge clk);
        do_rd  = b_rd;
        erd    = exp_read(b_addr);
        zero   = b_wr && b_addr == 6'd0 && b_wdata[1];
        done   = m_state && !zero && (m_lo >= m_per);
        cap_ev = b_sof || b_eot;
        for (int i = 0; i < 2; i++) begin
            lh[i] = m_state && (m_lo == m_lcmp[i]);
            hh[i] = done && (8'(m_hi + 1) == m_hcmp[i]);
        end
        set = {cap_ev, done && (m_hi == 8'hFF), hh, lh};
        clr = (b_wr && b_addr == 6'd56) ? b_wdata[5:0] : 6'd0;
        if (b_rd && b_addr == 6'd48) m_shadow = m_cap[15:8];
        if (cap_ev) m_cap = {m_hi, m_lo};
        if (!m_state || done) m_per = m_pend;
        if (zero) begin m_lo = 0; m_hi = 0; end
        else if (done) begin m_lo = 0; m_hi = m_hi + 1; end
        else if (m_state) m_lo = m_lo + 1;
        m_state = m_ctrl;
        if (b_wr) begin
            case (b_addr)
                6'd0:  m_ctrl = b_wdata[0];
                6'd8:  m_pend = b_wdata;
                6'd16: m_lcmp[0] = b_wdata;
                6'd24: m_lcmp[1] = b_wdata;
                6'd32: m_hcmp[0] = b_wdata;
                6'd40: m_hcmp[1] = b_wdata;
                default: ;
            endcase
        end
        m_lp = lh;
        m_hp = hh;
        m_flags = (m_flags & ~clr) | set;
        @(negedge clk);
        check(lo_match == m_lp, "R6", lo_match, m_lp);
        check(hi_match == m_hp, "R7", hi_match, m_hp);
        check(flags_out == m_flags, "R8", flags_out, m_flags);
        if (do_rd) check(rdata == erd, rd_tag, rdata, erd);
        b_wr = 0; b_rd = 0; b_sof = 0; b_eot = 0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        b_wr = 1; b_addr = a; b_wdata = d;
        step();
    endtask

    task automatic rd(input logic [5:0] a, input string tag);
        b_rd = 1; b_addr = a; rd_tag = tag;
        step();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        m_lo = 0; m_hi = 0; m_per = 8'hFF; m_pend = 8'hFF; m_state = 0; m_ctrl = 0;
        m_lcmp[0] = 0; m_lcmp[1] = 0; m_hcmp[0] = 0; m_hcmp[1] = 0;
        m_cap = 0; m_shadow = 0; m_flags = 0; m_lp = 0; m_hp = 0; rd_tag = "R10";
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        check(flags_out == 0, "R8", flags_out, 0);
        check(lo_match == 0 && hi_match == 0, "R6", {lo_match, hi_match}, 0);
        rd(6'd8, "R4");          // period reset value all ones
        rd(6'd48, "R5");         // capture reset value
        wr(6'd9, 8'h55);         // lane above width
        rd(6'd9, "R10");

        for (int k = 0; k < 5; k++) begin
            int p, n;
            p = (k == 0) ? 0 : (k == 4) ? 6 : k;
            n = (p + 2) * 256 + 60;
            wr(6'd0, 8'h02);     // stop and zero
            wr(6'd8, 8'(p));
            wr(6'd16, 8'(p / 2));
            wr(6'd24, 8'(p));
            wr(6'd32, 8'(k * 40 + 3));
            wr(6'd40, 8'h00);
            wr(6'd0, 8'h01);     // run
            for (int i = 0; i < n; i++) begin
                if (i % 29 == 0) begin
                    if (i % 2 == 0) b_sof = 1; else b_eot = 1;
                end
                if (i % 29 == 3) begin b_rd = 1; b_addr = 6'd48; rd_tag = "R1"; end
                if (i % 29 == 4) begin b_rd = 1; b_addr = 6'd49; rd_tag = "R2"; end
                if (i == (p + 1) * 100 + 1) begin b_wr = 1; b_addr = 6'd8; b_wdata = 8'(p + 1); end
                if (i % 500 == 250) begin b_wr = 1; b_addr = 6'd56; b_wdata = 8'h3F; end
                step();
            end
            rd(6'd56, "R9");
            rd(6'd8, "R4");
        end

        // stopped: counters hold
        wr(6'd0, 8'h00);
        idle(3);
        b_sof = 1; step();
        idle(30);
        b_eot = 1; step();
        rd(6'd48, "R3");
        rd(6'd49, "R3");
        rd(6'd0, "R10");

        // coherent capture read across a new strobe
        wr(6'd8, 8'h02);
        wr(6'd0, 8'h01);
        idle(20);
        b_sof = 1; step();
        rd(6'd48, "R5");
        idle(15);
        b_eot = 1; step();
        rd(6'd49, "R5");
        rd(6'd48, "R5");
        rd(6'd49, "R5");
        // clear with simultaneous capture set: set wins
        b_wr = 1; b_addr = 6'd56; b_wdata = 8'h3F; b_sof = 1; step();
        rd(6'd56, "R8");

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule